// File: doc/BRIEF.md
# Word-to-Byte Register Bridge

This block is a bus slave that lets a 32-bit processor bus reach a small file of 8-bit registers. It answers Wishbone classic cycles that fall inside one address window. Each word access is split into four byte operations that run one per clock, over the four byte addresses the word covers. A decoder turns each byte address into a register index or marks it as unmapped. The master is stalled for the whole sequence and gets a single acknowledge at the end.

The same byte registers can be read and written through a second byte-wide port, which stands in for an external serial access path. Its read data is combinational from the addressed register. Its write lands on the next rising edge. When both sides write one register in the same cycle, the second port's value is kept.

Data only moves on request at both ports. A master that is stalled waits on ack, and the second port is always ready. So the block has no valid/ready pins: the bus ack is its only back-pressure, and the second port never pushes back.

Top module: `wb_byte_bridge`

## Requirements
- R1: A cycle (cyc_i and stb_i high) is acknowledged only when adr_i[31:20] equals 0x260 (the window starting at 0x26000000, parameter BASE_ADDR, BLOCK_BITS = 20). A cycle outside the window is never acknowledged.
- R2: When the bridge is idle and sees an in-window request at a rising edge, ack_o goes high right after the fourth following rising edge. It stays high for exactly one cycle, provided the request is held.
- R3: Register i sits at byte offset i from the window base, for i below NUM_REGS (22). Byte offset 4w+k of word w uses data bits [8k+7:8k], for k = 0 to 3.
- R4: On a write, a byte whose sel_i bit is 0 keeps its old value. The sequence still takes four steps, so the ack timing of R2 does not change.
- R5: On a read, dat_o carries the assembled word during the ack cycle. dat_o is 0x00000000 in every cycle without ack, and also on write acks.
- R6: A byte offset at or above NUM_REGS reads as 0x00 and ignores writes, and the access still completes with ack.
- R7: If cyc_i or stb_i falls before ack, the bridge returns to idle and raises no ack. A later request is served normally.
- R8: Second port: sp_rdata shows register sp_addr combinationally (0x00 when sp_addr >= NUM_REGS). A high sp_wen writes sp_wdata to that register on the next rising edge.
- R9: If the second port and a bus byte step write the same register at the same edge, the second port's value is stored.
- R10: After reset, every register reads 0x00, ack_o is low and dat_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| sel_i | input | 4 | Byte lane enables, bit k for bits [8k+7:8k] |
| adr_i | input | 32 | Byte address, word aligned |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid with ack_o |
| ack_o | output | 1 | One-cycle acknowledge |
| sp_wen | input | 1 | Second port write enable |
| sp_addr | input | 8 | Second port register address |
| sp_wdata | input | 8 | Second port write data |
| sp_rdata | output | 8 | Second port read data |

## Verification
A sequencer stuck in a step, or counting the wrong way, shows at the ports as an ack that comes early, late or never. The bench measures ack latency on every access, so such a fault shows within five cycles of a request. A wrong step-to-lane mapping or a bad decoder places bytes in the wrong lane or in the wrong register. This shows on the next bus read, or at once on sp_rdata. The same-edge write test shows a reversed priority on the second port in the cycle after the collision.

// File: rtl/wbb_pkg.sv
package wbb_pkg;
  localparam int LANES = 4;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STEP,
    ST_ACK
  } seq_state_t;
endpackage

// File: rtl/wbb_decode.sv
module wbb_decode #(
  parameter int BLOCK_BITS = 20,
  parameter int NUM_REGS   = 22,
  parameter int IDX_W      = 5
) (
  input  logic [BLOCK_BITS-1:0] word_off,
  input  logic [1:0]            step,
  output logic [IDX_W-1:0]      idx,
  output logic                  hit
);
  logic [BLOCK_BITS-1:0] byte_off;

  always_comb begin
    byte_off = {word_off[BLOCK_BITS-1:2], step};
    hit      = byte_off < BLOCK_BITS'(NUM_REGS);
    idx      = byte_off[IDX_W-1:0];
  end
endmodule

// File: rtl/wbb_regfile.sv
module wbb_regfile #(
  parameter int NUM_REGS = 22,
  parameter int IDX_W    = 5,
  parameter int SP_AW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             sp_wen,
  input  logic [SP_AW-1:0] sp_addr,
  input  logic [7:0]       sp_wdata,
  output logic [7:0]       sp_rdata
);
  logic [7:0] regs [NUM_REGS];

  // second port wins a same-edge collision
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst)
        regs[i] <= 8'h00;
      else if (sp_wen && sp_addr == SP_AW'(i))
        regs[i] <= sp_wdata;
      else if (bus_we && bus_idx == IDX_W'(i))
        regs[i] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    sp_rdata  = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (bus_idx == IDX_W'(i)) bus_rdata = regs[i];
      if (sp_addr == SP_AW'(i)) sp_rdata = regs[i];
    end
  end
endmodule

// File: rtl/wbb_seq.sv
module wbb_seq
  import wbb_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'h2600_0000,
  parameter int          BLOCK_BITS = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cyc_i,
  input  logic                  stb_i,
  input  logic                  we_i,
  input  logic [3:0]            sel_i,
  input  logic [31:0]           adr_i,
  input  logic [31:0]           dat_i,
  input  logic [7:0]            rbyte,
  input  logic                  rhit,
  output logic                  step_wr,
  output logic [1:0]            step,
  output logic [7:0]            wbyte,
  output logic [BLOCK_BITS-1:0] word_off,
  output logic                  ack_o,
  output logic [31:0]           dat_o
);
  seq_state_t                state;
  logic                      req, in_block, step_go;
  logic                      we_q;
  logic [3:0]                sel_q;
  logic [LANES-1:0][7:0]     wdat_q;
  logic [LANES-1:0][7:0]     hold;

  always_comb begin
    req      = cyc_i && stb_i;
    in_block = adr_i[31:BLOCK_BITS] == BASE_ADDR[31:BLOCK_BITS];
    step_go  = (state == ST_STEP) && req;
    step_wr  = step_go && we_q && sel_q[step];
    wbyte    = wdat_q[step];
    ack_o    = (state == ST_ACK);
    dat_o    = ack_o ? hold : 32'h0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      step     <= 2'd0;
      we_q     <= 1'b0;
      sel_q    <= 4'h0;
      wdat_q   <= '0;
      word_off <= '0;
      hold     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req && in_block) begin
            state    <= ST_STEP;
            step     <= 2'd0;
            we_q     <= we_i;
            sel_q    <= sel_i;
            wdat_q   <= dat_i;
            word_off <= {adr_i[BLOCK_BITS-1:2], 2'b00};
            hold     <= '0;
          end
        end
        ST_STEP: begin
          if (!req) begin
            state <= ST_IDLE;
          end else begin
            if (!we_q) hold[step] <= rhit ? rbyte : 8'h00;
            if (step == 2'd3) state <= ST_ACK;
            else              step  <= 2'(step + 2'd1);
          end
        end
        ST_ACK:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wb_byte_bridge.sv
module wb_byte_bridge #(
  parameter logic [31:0] BASE_ADDR  = 32'h2600_0000,
  parameter int          BLOCK_BITS = 20,
  parameter int          NUM_REGS   = 22,
  parameter int          SP_AW      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cyc_i,
  input  logic             stb_i,
  input  logic             we_i,
  input  logic [3:0]       sel_i,
  input  logic [31:0]      adr_i,
  input  logic [31:0]      dat_i,
  output logic [31:0]      dat_o,
  output logic             ack_o,
  input  logic             sp_wen,
  input  logic [SP_AW-1:0] sp_addr,
  input  logic [7:0]       sp_wdata,
  output logic [7:0]       sp_rdata
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic                  step_wr, hit, bus_we;
  logic [1:0]            step;
  logic [7:0]            wbyte, rbyte;
  logic [BLOCK_BITS-1:0] word_off;
  logic [IDX_W-1:0]      idx;

  assign bus_we = step_wr && hit;

  wbb_seq #(.BASE_ADDR(BASE_ADDR), .BLOCK_BITS(BLOCK_BITS)) u_seq (
    .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .sel_i(sel_i), .adr_i(adr_i), .dat_i(dat_i), .rbyte(rbyte), .rhit(hit),
    .step_wr(step_wr), .step(step), .wbyte(wbyte), .word_off(word_off),
    .ack_o(ack_o), .dat_o(dat_o)
  );

  wbb_decode #(.BLOCK_BITS(BLOCK_BITS), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
    .word_off(word_off), .step(step), .idx(idx), .hit(hit)
  );

  wbb_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .SP_AW(SP_AW)) u_rf (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_idx(idx), .bus_wdata(wbyte),
    .bus_rdata(rbyte), .sp_wen(sp_wen), .sp_addr(sp_addr),
    .sp_wdata(sp_wdata), .sp_rdata(sp_rdata)
  );
endmodule

// File: rtl/wbb_checker.sv
module wbb_checker #(
  parameter logic [31:0] BASE_ADDR  = 32'h2600_0000,
  parameter int          BLOCK_BITS = 20,
  parameter int          NUM_REGS   = 22,
  parameter int          SP_AW      = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_i,
  input logic             stb_i,
  input logic [31:0]      adr_i,
  input logic [31:0]      dat_o,
  input logic             ack_o,
  input logic             sp_wen,
  input logic [SP_AW-1:0] sp_addr,
  input logic [7:0]       sp_wdata,
  input logic [7:0]       sp_rdata
);
  logic [2:0] run;
  logic       live_req;

  assign live_req = cyc_i && stb_i && (adr_i[31:BLOCK_BITS] == BASE_ADDR[31:BLOCK_BITS]);

  // edges in a row with an in-window request held, saturating
  always_ff @(posedge clk) begin
    if (rst)            run <= 3'd0;
    else if (!live_req) run <= 3'd0;
    else if (run != 3'd7) run <= 3'(run + 3'd1);
  end

  // R1 and R7: ack needs an unbroken in-window request of five edges
  assert_req_block_R1: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (run >= 3'd5));

  assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> !ack_o);

  assert_idle_data_R5: assert property (@(posedge clk) disable iff (rst)
    !ack_o |-> (dat_o == 32'h0));

  // R8 and R9: a mapped second-port write is always what is stored
  assert_sp_write_R9: assert property (@(posedge clk) disable iff (rst)
    (sp_wen && 32'(sp_addr) < 32'(NUM_REGS)) |=>
      ((sp_addr != $past(sp_addr)) || (sp_rdata == $past(sp_wdata))));
endmodule

bind wb_byte_bridge wbb_checker #(
  .BASE_ADDR(BASE_ADDR), .BLOCK_BITS(BLOCK_BITS), .NUM_REGS(NUM_REGS), .SP_AW(SP_AW)
) u_chk (
  .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .adr_i(adr_i),
  .dat_o(dat_o), .ack_o(ack_o), .sp_wen(sp_wen), .sp_addr(sp_addr),
  .sp_wdata(sp_wdata), .sp_rdata(sp_rdata)
);

// File: tb/wb_byte_bridge_bench.sv
module wb_byte_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc_i = 0, stb_i = 0, we_i = 0;
  logic [3:0]  sel_i = 0;
  logic [31:0] adr_i = 0, dat_i = 0;
  logic [31:0] dat_o;
  logic        ack_o;
  logic        sp_wen = 0;
  logic [7:0]  sp_addr = 0, sp_wdata = 0, sp_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wb_byte_bridge u_wb_byte_bridge (
    .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .sel_i(sel_i), .adr_i(adr_i), .dat_i(dat_i), .dat_o(dat_o), .ack_o(ack_o),
    .sp_wen(sp_wen), .sp_addr(sp_addr), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata)
  );

  // {we, sel, window offset, write data, expected read data}
  localparam int NV = 9;
  localparam logic [84:0] VEC [NV] = '{
    {1'b1, 4'hF, 16'h0000, 32'h4433_2211, 32'h0},          // R3 full word
    {1'b0, 4'hF, 16'h0000, 32'h0,         32'h4433_2211},  // R3 R5
    {1'b1, 4'h5, 16'h0004, 32'hAABB_CCDD, 32'h0},          // R4 lanes 0,2
    {1'b0, 4'hF, 16'h0004, 32'h0,         32'h00BB_00DD},  // R4
    {1'b1, 4'hF, 16'h0014, 32'h8765_4321, 32'h0},          // R6 half mapped
    {1'b0, 4'hF, 16'h0014, 32'h0,         32'h0000_4321},  // R6
    {1'b1, 4'h8, 16'h0000, 32'h9900_0000, 32'h0},          // R4 top lane
    {1'b0, 4'hF, 16'h0000, 32'h0,         32'h9933_2211},  // R3 R4
    {1'b0, 4'hF, 16'h0100, 32'h0,         32'h0}           // R6 unmapped word
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // drives a request at a falling edge and counts falling edges until ack
  task automatic bus_xfer(input logic we, input logic [3:0] sel, input logic [31:0] adr,
                          input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    cyc_i = 1; stb_i = 1; we_i = we; sel_i = sel; adr_i = adr; dat_i = wd;
    lat = 0; rd = 32'hDEAD_BEEF;
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      if (ack_o) begin lat = n; rd = dat_o; break; end
    end
    cyc_i = 0; stb_i = 0; we_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int lat;
    int seen;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 ack", {31'd0, ack_o}, 32'd0);
    chk("R10 dat_o", dat_o, 32'd0);
    chk("R10 reg0", {24'd0, sp_rdata}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      bus_xfer(VEC[v][84], VEC[v][83:80], {16'h2600, VEC[v][79:64]},
               VEC[v][63:32], rd, lat);
      chk($sformatf("R2 latency vec %0d", v), lat, 5);
      chk($sformatf("R5 data vec %0d", v), rd, VEC[v][31:0]);
      @(negedge clk);
      chk("R2 ack one cycle", {31'd0, ack_o}, 32'd0);
    end

    // R1 outside window: held 12 cycles, no ack
    @(negedge clk);
    cyc_i = 1; stb_i = 1; we_i = 0; sel_i = 4'hF; adr_i = 32'h2700_0000;
    seen = 0;
    for (int n = 0; n < 12; n++) begin @(negedge clk); if (ack_o) seen++; end
    cyc_i = 0; stb_i = 0;
    chk("R1 no ack outside window", seen, 0);

    // R7 abort after two edges, then a normal read
    @(negedge clk);
    cyc_i = 1; stb_i = 1; we_i = 0; sel_i = 4'hF; adr_i = 32'h2600_0000;
    repeat (2) @(negedge clk);
    stb_i = 0;
    seen = 0;
    for (int n = 0; n < 8; n++) begin @(negedge clk); if (ack_o) seen++; end
    cyc_i = 0;
    chk("R7 no ack after abort", seen, 0);
    bus_xfer(1'b0, 4'hF, 32'h2600_0000, 32'h0, rd, lat);
    chk("R7 next read latency", lat, 5);
    chk("R7 next read data", rd, 32'h9933_2211);

    // R8 second port write and read, unmapped address
    @(negedge clk);
    sp_wen = 1; sp_addr = 8'd10; sp_wdata = 8'h5A;
    @(negedge clk);
    sp_wen = 0;
    chk("R8 sp readback", {24'd0, sp_rdata}, 32'h5A);
    bus_xfer(1'b0, 4'hF, 32'h2600_0008, 32'h0, rd, lat);
    chk("R8 bus sees sp write lane 2", rd, 32'h005A_0000);
    sp_addr = 8'd30;
    #1 chk("R6 sp unmapped reads zero", {24'd0, sp_rdata}, 32'h0);

    // R9 collision on register 8 at the first step edge
    @(negedge clk);
    cyc_i = 1; stb_i = 1; we_i = 1; sel_i = 4'hF; adr_i = 32'h2600_0008; dat_i = 32'h1122_3344;
    @(negedge clk);
    sp_wen = 1; sp_addr = 8'd8; sp_wdata = 8'hEE;
    @(negedge clk);
    sp_wen = 0;
    for (int n = 0; n < 20; n++) begin @(negedge clk); if (ack_o) break; end
    cyc_i = 0; stb_i = 0; we_i = 0;
    chk("R9 second port wins", {24'd0, sp_rdata}, 32'hEE);
    sp_addr = 8'd9;
    #1 chk("R9 other bytes from bus", {24'd0, sp_rdata}, 32'h33);
    bus_xfer(1'b0, 4'hF, 32'h2600_0008, 32'h0, rd, lat);
    chk("R9 word after collision", rd, 32'h1122_33EE);

    finish_run();
  end
endmodule